// File: doc/BRIEF.md
# PS/2 Host Controller Register Interface

This block is the host-facing register front end of a two-channel controller that serves a keyboard and an auxiliary pointing device. The host reaches it over a byte-wide bus with two addresses. Address 0 is the data port and address 1 is the command/status port. Inside the block are a status byte, a configuration byte, one shared output data register, and a pending-command state. The pending-command state decides where the next data-port write goes.

Bytes from the devices arrive on two receive streams, one per channel, each using valid/ready. When the output register is free, or is being emptied by a data read in the same cycle, the block pops one byte and loads it into the output register. The keyboard stream always wins over the auxiliary stream. While the output register is full, `kbd_rx_ready` and `aux_rx_ready` stay low, so a device must hold its byte and `valid` until it is taken. Host bytes sent to a device leave as a one-cycle `*_tx_valid` strobe with no back-pressure, so the device side must accept every strobe. Each channel has a one-cycle interrupt pulse, and commands the block does not support raise a one-cycle error pulse.

Top module: `ps2_host_regs`

## Requirements
- R1: A read (`bus_valid`=1, `bus_write`=0) at address 1 returns the status byte in the same cycle. Status bits are: bit0 output-full, bit2 self-test-ok, bit3 last-write-was-command, bit4 unlocked, bit5 aux-output-full; all other bits read 0. A read at address 0 returns the output register and clears output-full and aux-output-full.
- R2: When the output register is empty, or is being read in this cycle, a waiting keyboard byte is popped and loaded. An auxiliary byte is popped only when no keyboard byte is waiting. While the register is full and not being read, nothing is popped.
- R3: Every load of the output register sets output-full. Aux-output-full is set only when the loaded byte is tagged as coming from the auxiliary channel.
- R4: `kbd_irq` pulses for one cycle, in the cycle after a keyboard-tagged load, if configuration bit0 is set. `aux_irq` does the same for an auxiliary-tagged load if configuration bit1 is set.
- R5: A write to address 1 sets status bit3. A write to address 0 clears it.
- R6: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 only record a pending command. The next write to address 0 is consumed by that command, and the pending state then returns to none. The byte that follows 0xD1 is discarded.
- R7: A write to address 0 with nothing pending produces a one-cycle `kbd_tx_valid` carrying the byte. With 0xD4 pending, it produces `aux_tx_valid` instead.
- R8: After 0xD2, the next data byte is loaded into the output register tagged as keyboard. After 0xD3, it is loaded tagged as auxiliary, with the interrupts of R4.
- R9: Command 0x20 loads the configuration byte into the output register, tagged as keyboard. The byte that follows 0x60 replaces the configuration byte, and its bit2 is copied into status bit2.
- R10: Commands 0xAD and 0xAE set and clear configuration bit4. Commands 0xA7 and 0xA8 set and clear configuration bit5. None of these four commands changes the output register.
- R11: After reset, the status byte is 0x1C and the configuration byte is 0x45 (bit0 keyboard irq enable, bit2 self-test, bit6 translate).
- R12: Any other command code produces a one-cycle `cmd_err` pulse in the next cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data port, 1 = command/status port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the access cycle |
| kbd_rx_valid | input | 1 | Keyboard byte waiting |
| kbd_rx_data | input | 8 | Keyboard byte |
| kbd_rx_ready | output | 1 | Keyboard byte taken when high with valid |
| aux_rx_valid | input | 1 | Auxiliary byte waiting |
| aux_rx_data | input | 8 | Auxiliary byte |
| aux_rx_ready | output | 1 | Auxiliary byte taken when high with valid |
| kbd_tx_valid | output | 1 | Byte strobe to keyboard |
| kbd_tx_data | output | 8 | Byte to keyboard |
| aux_tx_valid | output | 1 | Byte strobe to auxiliary device |
| aux_tx_data | output | 8 | Byte to auxiliary device |
| kbd_irq | output | 1 | Keyboard interrupt pulse |
| aux_irq | output | 1 | Auxiliary interrupt pulse |
| cmd_err | output | 1 | Unsupported command pulse |

## Verification
The bench presents keyboard and auxiliary bytes in the same cycle. A design with the wrong priority would return the auxiliary byte first, or would set aux-output-full on a keyboard byte. The bench also fills the output register through a command and then offers a keyboard byte, so a design that ignored back-pressure would overwrite the unread byte. It checks that a discarded output-port byte leaves the pending state at none: a design that kept it pending would swallow the next keyboard write. It also checks that the enable/disable commands and the self-test copy touch only their own bits, since a wrong design would corrupt the output register or the status byte.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
  localparam int unsigned BYTE_W = 8;

  // status bit positions
  localparam int ST_OBF  = 0;
  localparam int ST_SELF = 2;
  localparam int ST_CMD  = 3;
  localparam int ST_UNLK = 4;
  localparam int ST_AOBF = 5;

  // configuration bit positions
  localparam int CF_KIE  = 0;
  localparam int CF_AIE  = 1;
  localparam int CF_SELF = 2;
  localparam int CF_KDIS = 4;
  localparam int CF_ADIS = 5;

  localparam logic [BYTE_W-1:0] CFG_RESET = 8'h45;

  // command codes
  localparam logic [7:0] OP_RD_CFG  = 8'h20;
  localparam logic [7:0] OP_WR_CFG  = 8'h60;
  localparam logic [7:0] OP_AUX_OFF = 8'hA7;
  localparam logic [7:0] OP_AUX_ON  = 8'hA8;
  localparam logic [7:0] OP_KBD_OFF = 8'hAD;
  localparam logic [7:0] OP_KBD_ON  = 8'hAE;
  localparam logic [7:0] OP_WR_OPRT = 8'hD1;
  localparam logic [7:0] OP_LD_KBUF = 8'hD2;
  localparam logic [7:0] OP_LD_ABUF = 8'hD3;
  localparam logic [7:0] OP_TO_AUX  = 8'hD4;

  typedef enum logic [2:0] {
    PEND_NONE,
    PEND_CFG,
    PEND_OPORT,
    PEND_KBUF,
    PEND_ABUF,
    PEND_AUX
  } pend_e;

  typedef struct packed {
    pend_e next_pend;
    logic  read_cfg;
    logic  kbd_off;
    logic  kbd_on;
    logic  aux_off;
    logic  aux_on;
    logic  unsup;
  } cmd_act_t;
endpackage

// File: rtl/ps2h_cmd_decode.sv
module ps2h_cmd_decode
  import ps2h_pkg::*;
(
  input  logic [7:0] code,
  output cmd_act_t   act
);
  always_comb begin
    act = '{next_pend: PEND_NONE, default: 1'b0};
    unique case (code)
      OP_RD_CFG:  act.read_cfg  = 1'b1;
      OP_WR_CFG:  act.next_pend = PEND_CFG;
      OP_AUX_OFF: act.aux_off   = 1'b1;
      OP_AUX_ON:  act.aux_on    = 1'b1;
      OP_KBD_OFF: act.kbd_off   = 1'b1;
      OP_KBD_ON:  act.kbd_on    = 1'b1;
      OP_WR_OPRT: act.next_pend = PEND_OPORT;
      OP_LD_KBUF: act.next_pend = PEND_KBUF;
      OP_LD_ABUF: act.next_pend = PEND_ABUF;
      OP_TO_AUX:  act.next_pend = PEND_AUX;
      default:    act.unsup     = 1'b1;
    endcase
  end
endmodule

// File: rtl/ps2h_outbuf.sv
module ps2h_outbuf #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_take,
  input  logic          host_load,
  input  logic [DW-1:0] host_byte,
  input  logic          host_aux,
  input  logic          kie,
  input  logic          aie,
  input  logic          kbd_valid,
  input  logic [DW-1:0] kbd_data,
  output logic          kbd_ready,
  input  logic          aux_valid,
  input  logic [DW-1:0] aux_data,
  output logic          aux_ready,
  output logic [DW-1:0] out_byte,
  output logic          full,
  output logic          aux_flag,
  output logic          kbd_irq,
  output logic          aux_irq
);
  logic          room;
  logic          kpop, apop, load, ld_aux;
  logic [DW-1:0] ld_byte;

  assign room      = !full || rd_take;
  assign kbd_ready = room && !host_load;
  assign aux_ready = room && !host_load && !kbd_valid;
  assign kpop      = kbd_ready && kbd_valid;
  assign apop      = aux_ready && aux_valid;
  assign load      = host_load || kpop || apop;

  always_comb begin
    if (host_load) begin
      ld_byte = host_byte;
      ld_aux  = host_aux;
    end else if (kpop) begin
      ld_byte = kbd_data;
      ld_aux  = 1'b0;
    end else begin
      ld_byte = aux_data;
      ld_aux  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_byte <= '0;
      full     <= 1'b0;
      aux_flag <= 1'b0;
      kbd_irq  <= 1'b0;
      aux_irq  <= 1'b0;
    end else begin
      if (load) begin
        out_byte <= ld_byte;
        full     <= 1'b1;
        aux_flag <= ld_aux;
      end else if (rd_take) begin
        full     <= 1'b0;
        aux_flag <= 1'b0;
      end
      kbd_irq <= load && !ld_aux && kie;
      aux_irq <= load && ld_aux && aie;
    end
  end

  // R2
  aux_yields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_ready && aux_valid) |-> !kbd_valid);
  // R2
  hold_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_take) |-> (!kbd_ready && !aux_ready));
  // R3
  load_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> full);
  // R4
  kbd_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_irq |-> (full && !aux_flag));
  // R4
  aux_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_irq |-> (full && aux_flag));
endmodule

// File: rtl/ps2_host_regs.sv
module ps2_host_regs
  import ps2h_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic        bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        kbd_rx_valid,
  input  logic [7:0]  kbd_rx_data,
  output logic        kbd_rx_ready,
  input  logic        aux_rx_valid,
  input  logic [7:0]  aux_rx_data,
  output logic        aux_rx_ready,
  output logic        kbd_tx_valid,
  output logic [7:0]  kbd_tx_data,
  output logic        aux_tx_valid,
  output logic [7:0]  aux_tx_data,
  output logic        kbd_irq,
  output logic        aux_irq,
  output logic        cmd_err
);
  logic        wr_data, wr_cmd, rd_data;
  cmd_act_t    act;
  pend_e       pend;
  logic [7:0]  cfg;
  logic        cmd_flag, self_ok, unlocked;
  logic        host_load, host_aux;
  logic [7:0]  host_byte;
  logic [7:0]  out_byte;
  logic        full, aux_flag;
  logic [7:0]  status;

  assign wr_data = bus_valid && bus_write && !bus_addr;
  assign wr_cmd  = bus_valid && bus_write && bus_addr;
  assign rd_data = bus_valid && !bus_write && !bus_addr;

  ps2h_cmd_decode u_dec (
    .code (bus_wdata),
    .act  (act)
  );

  always_comb begin
    host_load = 1'b0;
    host_aux  = 1'b0;
    host_byte = bus_wdata;
    if (wr_cmd && act.read_cfg) begin
      host_load = 1'b1;
      host_byte = cfg;
    end else if (wr_data && pend == PEND_KBUF) begin
      host_load = 1'b1;
    end else if (wr_data && pend == PEND_ABUF) begin
      host_load = 1'b1;
      host_aux  = 1'b1;
    end
  end

  ps2h_outbuf #(.DW(BYTE_W)) u_obuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_take   (rd_data),
    .host_load (host_load),
    .host_byte (host_byte),
    .host_aux  (host_aux),
    .kie       (cfg[CF_KIE]),
    .aie       (cfg[CF_AIE]),
    .kbd_valid (kbd_rx_valid),
    .kbd_data  (kbd_rx_data),
    .kbd_ready (kbd_rx_ready),
    .aux_valid (aux_rx_valid),
    .aux_data  (aux_rx_data),
    .aux_ready (aux_rx_ready),
    .out_byte  (out_byte),
    .full      (full),
    .aux_flag  (aux_flag),
    .kbd_irq   (kbd_irq),
    .aux_irq   (aux_irq)
  );

  always_comb begin
    status          = '0;
    status[ST_OBF]  = full;
    status[ST_SELF] = self_ok;
    status[ST_CMD]  = cmd_flag;
    status[ST_UNLK] = unlocked;
    status[ST_AOBF] = aux_flag;
  end

  assign bus_rdata = bus_addr ? status : out_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend         <= PEND_NONE;
      cfg          <= CFG_RESET;
      cmd_flag     <= 1'b1;
      self_ok      <= 1'b1;
      unlocked     <= 1'b1;
      kbd_tx_valid <= 1'b0;
      aux_tx_valid <= 1'b0;
      kbd_tx_data  <= '0;
      aux_tx_data  <= '0;
      cmd_err      <= 1'b0;
    end else begin
      kbd_tx_valid <= wr_data && pend == PEND_NONE;
      aux_tx_valid <= wr_data && pend == PEND_AUX;
      if (wr_data) begin
        kbd_tx_data <= bus_wdata;
        aux_tx_data <= bus_wdata;
      end
      cmd_err <= wr_cmd && act.unsup;
      if (wr_cmd) begin
        cmd_flag <= 1'b1;
        pend     <= act.next_pend;
        if (act.kbd_off) cfg[CF_KDIS] <= 1'b1;
        if (act.kbd_on)  cfg[CF_KDIS] <= 1'b0;
        if (act.aux_off) cfg[CF_ADIS] <= 1'b1;
        if (act.aux_on)  cfg[CF_ADIS] <= 1'b0;
      end else if (wr_data) begin
        cmd_flag <= 1'b0;
        pend     <= PEND_NONE;
        if (pend == PEND_CFG) begin
          cfg     <= bus_wdata;
          self_ok <= bus_wdata[CF_SELF];
        end
      end
    end
  end

  // R5
  cmd_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> status[ST_CMD]);
  // R5
  cmd_flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !status[ST_CMD]);
  // R7
  kbd_tx_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_tx_valid |-> $past(wr_data));
  // R7
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kbd_tx_valid, aux_tx_valid}));
  // R12
  err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(wr_cmd));
  // R10
  toggle_keeps_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && (act.kbd_off || act.kbd_on || act.aux_off || act.aux_on)
     && !kbd_rx_ready && !aux_rx_ready) |=> $stable(out_byte));
endmodule

// File: tb/sim_ps2_host_regs.sv
module sim_ps2_host_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0, bus_write = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       kbd_rx_valid, kbd_rx_ready, aux_rx_valid, aux_rx_ready;
  logic [7:0] kbd_rx_data, aux_rx_data;
  logic       kbd_tx_valid, aux_tx_valid, kbd_irq, aux_irq, cmd_err;
  logic [7:0] kbd_tx_data, aux_tx_data;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // device receive models
  logic [7:0] kq [0:15];
  logic [7:0] aq [0:15];
  int kwr = 0, krd = 0, awr = 0, ard = 0;
  assign kbd_rx_valid = (kwr != krd);
  assign kbd_rx_data  = kq[krd % 16];
  assign aux_rx_valid = (awr != ard);
  assign aux_rx_data  = aq[ard % 16];

  int ktx_n = 0, atx_n = 0, kirq_n = 0, airq_n = 0, err_n = 0;
  logic [7:0] ktx_last = '0, atx_last = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (kbd_rx_valid && kbd_rx_ready) krd <= krd + 1;
      if (aux_rx_valid && aux_rx_ready) ard <= ard + 1;
      if (kbd_tx_valid) begin ktx_n <= ktx_n + 1; ktx_last <= kbd_tx_data; end
      if (aux_tx_valid) begin atx_n <= atx_n + 1; atx_last <= aux_tx_data; end
      if (kbd_irq) kirq_n <= kirq_n + 1;
      if (aux_irq) airq_n <= airq_n + 1;
      if (cmd_err) err_n  <= err_n + 1;
    end
  end

  ps2_host_regs u0 (.*);

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic a, logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(logic a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard
  logic [7:0] exp_q [$];
  int exp_kirq = 0, exp_airq = 0;

  task automatic expect_byte(logic [7:0] b);
    exp_q.push_back(b);
  endtask

  task automatic pop_cmp(string tag);
    logic [7:0] v, e;
    bus_rd(1'b0, v);
    e = exp_q.pop_front();
    chk(tag, v, e);
  endtask

  task automatic status_is(string tag, logic [7:0] e);
    logic [7:0] v;
    bus_rd(1'b1, v);
    chk(tag, v, e);
  endtask

  task automatic irqs_are(string tag);
    idle(2);
    chk({tag, " kbd_irq count"}, kirq_n, exp_kirq);
    chk({tag, " aux_irq count"}, airq_n, exp_airq);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    // R11 reset values
    status_is("R11 reset status", 8'h1C);
    // R9 read config byte
    bus_wr(1'b1, 8'h20); expect_byte(8'h45); exp_kirq++;
    irqs_are("R4 cfg load");
    status_is("R3 status after cfg load", 8'h1D);
    pop_cmp("R11 reset config");
    status_is("R1 read clears full", 8'h1C);

    // R2 simultaneous arrival: keyboard first
    @(negedge clk);
    kq[kwr % 16] = 8'hA1; aq[awr % 16] = 8'hB2; kwr++; awr++;
    expect_byte(8'hA1); expect_byte(8'hB2); exp_kirq++;
    irqs_are("R2 kbd first");
    status_is("R3 kbd tag", 8'h1D);
    pop_cmp("R2 kbd byte first");
    status_is("R3 aux tag after refill", 8'h3D);
    pop_cmp("R2 aux byte second");
    irqs_are("R4 aux irq disabled");

    // R9 write config, R8 aux buffer load
    bus_wr(1'b1, 8'h60); bus_wr(1'b0, 8'h47);
    status_is("R5 data write clears flag", 8'h14);
    bus_wr(1'b1, 8'hD3); bus_wr(1'b0, 8'h5A); expect_byte(8'h5A); exp_airq++;
    irqs_are("R8 aux buffer");
    status_is("R8 aux buffer status", 8'h35);
    pop_cmp("R8 aux buffer byte");

    // R9 self-test copy
    bus_wr(1'b1, 8'h60); bus_wr(1'b0, 8'h03);
    status_is("R9 self-test cleared", 8'h10);
    bus_wr(1'b1, 8'h20); expect_byte(8'h03); exp_kirq++;
    pop_cmp("R9 new config readback");
    bus_wr(1'b1, 8'h60); bus_wr(1'b0, 8'h47);
    status_is("R9 self-test restored", 8'h14);

    // R8 keyboard buffer load
    bus_wr(1'b1, 8'hD2); bus_wr(1'b0, 8'h77); expect_byte(8'h77); exp_kirq++;
    irqs_are("R8 kbd buffer");
    status_is("R8 kbd buffer status", 8'h15);
    pop_cmp("R8 kbd buffer byte");

    // R7 routing
    bus_wr(1'b0, 8'hF4); idle(2);
    chk("R7 kbd tx count", ktx_n, 1);
    chk("R7 kbd tx byte", ktx_last, 8'hF4);
    bus_wr(1'b1, 8'hD4); bus_wr(1'b0, 8'hE8); idle(2);
    chk("R7 aux tx count", atx_n, 1);
    chk("R7 aux tx byte", atx_last, 8'hE8);
    chk("R7 kbd tx untouched", ktx_n, 1);
    @(negedge clk);
    aq[awr % 16] = 8'hFA; awr++; expect_byte(8'hFA); exp_airq++;
    irqs_are("R4 aux reply");
    status_is("R3 aux reply status", 8'h35);
    pop_cmp("R7 aux reply byte");

    // R10 enable/disable
    bus_wr(1'b1, 8'hD2); bus_wr(1'b0, 8'h11); expect_byte(8'h11); exp_kirq++;
    bus_wr(1'b1, 8'hAD); bus_wr(1'b1, 8'hA7);
    pop_cmp("R10 output untouched");
    bus_wr(1'b1, 8'h20); expect_byte(8'h77); exp_kirq++;
    pop_cmp("R10 disable bits set");
    bus_wr(1'b1, 8'hAE); bus_wr(1'b1, 8'hA8);
    bus_wr(1'b1, 8'h20); expect_byte(8'h47); exp_kirq++;
    pop_cmp("R10 disable bits cleared");
    irqs_are("R10 irq tally");

    // R12 unsupported
    bus_wr(1'b1, 8'hC0); idle(2);
    chk("R12 error pulse", err_n, 1);
    status_is("R12 no state change", 8'h1C);

    // R6 output-port parameter is discarded, pending returns to none
    bus_wr(1'b1, 8'hD1); bus_wr(1'b0, 8'h01); idle(2);
    chk("R6 discarded byte not sent", ktx_n, 1);
    status_is("R6 discarded byte not loaded", 8'h14);
    bus_wr(1'b0, 8'h55); idle(2);
    chk("R6 pending cleared tx count", ktx_n, 2);
    chk("R6 pending cleared tx byte", ktx_last, 8'h55);

    // R2 back-pressure while full
    bus_wr(1'b1, 8'hD2); bus_wr(1'b0, 8'h33); expect_byte(8'h33); exp_kirq++;
    @(negedge clk);
    kq[kwr % 16] = 8'h44; kwr++; expect_byte(8'h44); exp_kirq++;
    idle(3);
    chk("R2 held while full", kwr - krd, 1);
    pop_cmp("R2 unread byte kept");
    pop_cmp("R2 held byte delivered");
    irqs_are("R4 final tally");
    chk("R12 no extra errors", err_n, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule